// File: doc/BRIEF.md
# Self-Calibration Start and Sequencing Controller

This block decides when a data converter runs its self-calibration cycle and reports whether one is in progress. After reset it counts a power-on delay, whose length a select input picks between two parameters, and then starts one automatic calibration. The analog calibration is modelled as a busy interval of a fixed number of clock cycles. All timing is counted on the sample clock only, so no counter moves while the clock is stopped.

A calibration can also be commanded through a request input. The request passes through a synchronizer and is then qualified. It must be seen low for at least `TCAL_L` consecutive cycles and then high for at least `TCAL_H` consecutive cycles. Short pulses of either polarity start nothing. If the request is already high when the power-on delay expires, the automatic run is skipped. In that case nothing runs until a full low-then-high sequence is seen.

While a calibration runs, the block watches a set of control inputs that must not move. Any change on one of them, a rising power-down, or a new rising request sets a sticky fault flag. The flag stays set after the run ends and clears when the next calibration starts.

Top module: `cal_seq_ctrl`

## Requirements
- R1: With the request low, `busy_o` rises after `PON_SHORT` clock edges following reset release when `dly_sel_i`=0, and after `PON_LONG` edges when `dly_sel_i`=1. It is low before that.
- R2: If the synchronized request is high when the power-on delay expires, no automatic calibration runs, and `busy_o` stays low while the request stays high.
- R3: A commanded calibration starts after the synchronized request has been low for at least `TCAL_L` consecutive cycles and then high for `TCAL_H` consecutive cycles. `busy_o` rises `TCAL_H`+2 edges after the first edge that samples the raw request high (2 of these edges are synchronizer delay).
- R4: A high period shorter than `TCAL_H` starts nothing. After such a failed high period, the low count restarts from zero, so a following low period shorter than `TCAL_L` does not qualify a later high period of any length.
- R5: Once started, `busy_o` stays high for exactly `CAL_CYCLES` cycles and then returns low.
- R6: While `busy_o` is high, any of the following sets `fault_o` on the next edge: a change on any bit of `cfg_i`, a rise of `pwrdn_i`, or a rise of the synchronized request. The `cfg_i` bits are: bit 0 output level, bit 1 output edge, bit 2 data rate, bits 3 and 4 enable modes, bit 5 clock reset, bit 6 serial select.
- R7: `fault_o` is low after reset. It stays set after the run ends and clears on the edge where the next calibration starts.
- R8: Changes on `cfg_i` and rises of `pwrdn_i` while `busy_o` is low leave `fault_o` unchanged.
- R9: A request held high after a calibration ends does not start another run; a new low period is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_req_i | input | 1 | Calibration request, asynchronous |
| dly_sel_i | input | 1 | Power-on delay select: 0 picks the short delay, 1 picks the long delay |
| cfg_i | input | NUM_CFG | Protected static control levels |
| pwrdn_i | input | 1 | Power-down request; a rise during a run is protected |
| busy_o | output | 1 | High while a calibration runs |
| fault_o | output | 1 | Sticky flag: a protected input moved during a run |

## Verification
The auto run is due on edge `PON_SHORT` or `PON_LONG` after reset release. A commanded run is due `TCAL_H`+2 edges after the raw request is first sampled high. A run ends exactly `CAL_CYCLES` edges after it begins. A fault is due one edge after a `cfg_i` or `pwrdn_i` move, and three edges after a raw request rise, because of the synchronizer. The bench drives every input one time unit after a rising edge and samples one time unit after a counted edge. For each timed result it checks the output as still unchanged one edge before the due edge and as changed on the due edge. The negative cases (glitches, suppressed power-on run, request held high, idle moves) are checked after a window longer than any qualifying delay.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } cal_st_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= 1'b0;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cal_req_qual.sv
module cal_req_qual #(
  parameter int TCAL_L = 32,
  parameter int TCAL_H = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic start_o
);
  localparam int LW = $clog2(TCAL_L + 1);
  localparam int HW = $clog2(TCAL_H + 1);
  localparam logic [LW-1:0] L_MAX = LW'(TCAL_L);
  localparam logic [LW-1:0] L_PRE = LW'(TCAL_L - 1);
  localparam logic [HW-1:0] H_LAST = HW'(TCAL_H - 1);

  logic [LW-1:0] lo_cnt_q;
  logic [HW-1:0] hi_cnt_q;
  logic          lo_ok_q;

  assign start_o = req_i & lo_ok_q & (hi_cnt_q == H_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q <= '0;
      hi_cnt_q <= '0;
      lo_ok_q  <= 1'b0;
    end else if (!req_i) begin
      hi_cnt_q <= '0;
      if (lo_cnt_q != L_MAX) lo_cnt_q <= lo_cnt_q + 1'b1;
      // qualified once this low sample brings the run to TCAL_L
      lo_ok_q  <= (lo_cnt_q >= L_PRE);
    end else begin
      lo_cnt_q <= '0;
      if (start_o) begin
        lo_ok_q  <= 1'b0;
        hi_cnt_q <= '0;
      end else if (lo_ok_q) begin
        hi_cnt_q <= hi_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_pon_timer.sv
module cal_pon_timer #(
  parameter int PON_SHORT = 256,
  parameter int PON_LONG  = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dly_sel_i,
  output logic fire_o
);
  localparam int DMAX = cal_seq_pkg::max_i(PON_SHORT, PON_LONG);
  localparam int DW   = $clog2(DMAX + 1);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] lim;
  logic          done_q;

  assign lim    = dly_sel_i ? DW'(PON_LONG - 1) : DW'(PON_SHORT - 1);
  assign fire_o = !done_q && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (fire_o) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cal_run_timer.sv
module cal_run_timer
  import cal_seq_pkg::*;
#(
  parameter int CAL_CYCLES = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic acc_o,
  output logic busy_o
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] C_LAST = CW'(CAL_CYCLES - 1);

  cal_st_e       st_q;
  logic [CW-1:0] cnt_q;

  assign acc_o  = start_i && (st_q == ST_IDLE);
  assign busy_o = (st_q == ST_BUSY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_BUSY;
          cnt_q <= '0;
        end
        ST_BUSY: if (cnt_q == C_LAST) begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cal_guard.sv
module cal_guard #(
  parameter int NUM_CFG = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CFG-1:0] cfg_i,
  input  logic               pwrdn_i,
  input  logic               req_s_i,
  input  logic               busy_i,
  input  logic               clr_i,
  output logic               fault_o
);
  logic [NUM_CFG-1:0] cfg_q;
  logic [NUM_CFG-1:0] chg;
  logic               pd_q;
  logic               rq_q;
  logic               ev;
  logic               fault_q;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_chg
    assign chg[g] = cfg_i[g] ^ cfg_q[g];
  end

  assign ev = (|chg) | (pwrdn_i & ~pd_q) | (req_s_i & ~rq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      pd_q    <= 1'b0;
      rq_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      cfg_q <= cfg_i;
      pd_q  <= pwrdn_i;
      rq_q  <= req_s_i;
      if (clr_i) fault_q <= 1'b0;
      else if (busy_i && ev) fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl #(
  parameter int TCAL_L      = 32,
  parameter int TCAL_H      = 32,
  parameter int PON_SHORT   = 256,
  parameter int PON_LONG    = 1024,
  parameter int CAL_CYCLES  = 512,
  parameter int NUM_CFG     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cal_req_i,
  input  logic               dly_sel_i,
  input  logic [NUM_CFG-1:0] cfg_i,
  input  logic               pwrdn_i,
  output logic               busy_o,
  output logic               fault_o
);
  logic req_s;
  logic cmd_start;
  logic pon_fire;
  logic start;
  logic acc;

  cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cal_req_i),
    .q_o   (req_s)
  );

  cal_req_qual #(.TCAL_L(TCAL_L), .TCAL_H(TCAL_H)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_s),
    .start_o(cmd_start)
  );

  cal_pon_timer #(.PON_SHORT(PON_SHORT), .PON_LONG(PON_LONG)) u_pon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dly_sel_i(dly_sel_i),
    .fire_o   (pon_fire)
  );

  // a request high at delay expiry suppresses the automatic run
  assign start = cmd_start | (pon_fire & ~req_s);

  cal_run_timer #(.CAL_CYCLES(CAL_CYCLES)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .acc_o  (acc),
    .busy_o (busy_o)
  );

  cal_guard #(.NUM_CFG(NUM_CFG)) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i),
    .pwrdn_i(pwrdn_i),
    .req_s_i(req_s),
    .busy_i (busy_o),
    .clr_i  (acc),
    .fault_o(fault_o)
  );
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
  parameter int TCAL_L     = 32,
  parameter int TCAL_H     = 32,
  parameter int PON_SHORT  = 256,
  parameter int PON_LONG   = 1024,
  parameter int CAL_CYCLES = 512
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic fault_o
);
  localparam int EARLY = cal_seq_pkg::min_i(cal_seq_pkg::min_i(PON_SHORT, PON_LONG), TCAL_L + TCAL_H);
  localparam int EW = $clog2(EARLY + 1);
  localparam int CW = $clog2(CAL_CYCLES + 1);

  logic [EW-1:0] cyc_q;
  logic [CW-1:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      bcnt_q <= '0;
    end else begin
      if (cyc_q != EW'(EARLY)) cyc_q <= cyc_q + 1'b1;
      bcnt_q <= busy_o ? bcnt_q + 1'b1 : '0;
    end
  end

  // R1, R3: no run can begin before the shortest possible start window
  a_r1_no_early_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < EW'(EARLY)) |-> !busy_o);

  a_r5_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (bcnt_q == CW'(CAL_CYCLES)));

  a_r5_busy_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bcnt_q < CW'(CAL_CYCLES)));

  a_r6_fault_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(busy_o));

  a_r7_fault_clr_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !fault_o);

  a_r7_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $rose(busy_o));
endmodule

bind cal_seq_ctrl cal_seq_chk #(
  .TCAL_L    (TCAL_L),
  .TCAL_H    (TCAL_H),
  .PON_SHORT (PON_SHORT),
  .PON_LONG  (PON_LONG),
  .CAL_CYCLES(CAL_CYCLES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .fault_o(fault_o)
);

// File: tb/sim_cal_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cal_seq_ctrl;
  localparam int TL = 8;
  localparam int TH = 6;
  localparam int PS = 20;
  localparam int PL = 40;
  localparam int CC = 30;
  localparam int NC = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic sel = 1'b0;
  logic [NC-1:0] cfg = '0;
  logic pd = 1'b0;
  logic busy, fault;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cal_seq_ctrl #(
    .TCAL_L(TL), .TCAL_H(TH), .PON_SHORT(PS), .PON_LONG(PL),
    .CAL_CYCLES(CC), .NUM_CFG(NC), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cal_req_i(req), .dly_sel_i(sel),
    .cfg_i(cfg), .pwrdn_i(pd), .busy_o(busy), .fault_o(fault)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string msg);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", msg, act, exp);
    end
  endtask

  task automatic reset_dut(input logic r, input logic s);
    rst_n = 1'b0;
    req = r;
    sel = s;
    cfg = '0;
    pd = 1'b0;
    tick(3);
    rst_n = 1'b1;
    chk(busy, 1'b0, "R7 reset busy");
    chk(fault, 1'b0, "R7 reset fault");
  endtask

  // qualified command from idle; checks the start edge
  task automatic cmd_cal(input string tag);
    req = 1'b0;
    tick(TL + 3);
    req = 1'b1;
    tick(TH + 1);
    chk(busy, 1'b0, {tag, " R3 busy before due edge"});
    tick(1);
    chk(busy, 1'b1, {tag, " R3 busy on due edge"});
  endtask

  task automatic t_auto(input logic s);
    int d;
    d = s ? PL : PS;
    reset_dut(1'b0, s);
    tick(d - 1);
    chk(busy, 1'b0, "R1 busy before power-on delay");
    tick(1);
    chk(busy, 1'b1, "R1 busy at power-on delay");
    tick(CC - 1);
    chk(busy, 1'b1, "R5 busy on last cycle");
    tick(1);
    chk(busy, 1'b0, "R5 busy cleared after CAL_CYCLES");
  endtask

  task automatic t_suppress;
    reset_dut(1'b1, 1'b0);
    tick(PS + 5);
    chk(busy, 1'b0, "R2 auto run suppressed");
    tick(60);
    chk(busy, 1'b0, "R2 held request starts nothing");
    cmd_cal("suppress");
    tick(CC);
    chk(busy, 1'b0, "R5 commanded run ended");
    tick(40);
    chk(busy, 1'b0, "R9 held request no rerun");
  endtask

  task automatic t_glitch;
    logic seen;
    reset_dut(1'b0, 1'b0);
    tick(PS + CC + 2);
    chk(busy, 1'b0, "R4 idle before glitches");
    seen = 1'b0;
    req = 1'b0;
    tick(TL + 3);
    req = 1'b1;
    tick(TH - 1);
    if (busy) seen = 1'b1;
    req = 1'b0;
    tick(TL - 4);
    if (busy) seen = 1'b1;
    req = 1'b1;
    for (int i = 0; i < TH + 10; i++) begin
      tick(1);
      if (busy) seen = 1'b1;
    end
    chk(seen, 1'b0, "R4 short pulses start nothing");
    cmd_cal("glitch");
    tick(CC);
  endtask

  task automatic t_guard;
    reset_dut(1'b0, 1'b0);
    tick(PS + CC + 2);
    cfg[2] = ~cfg[2];
    tick(2);
    chk(fault, 1'b0, "R8 idle cfg change ignored");
    pd = 1'b1;
    tick(2);
    chk(fault, 1'b0, "R8 idle power-down rise ignored");
    pd = 1'b0;
    for (int i = 0; i < NC; i++) begin
      cmd_cal("guard");
      chk(fault, 1'b0, "R7 fault clear at start");
      tick(2);
      cfg[i] = ~cfg[i];
      tick(1);
      chk(fault, 1'b1, "R6 cfg change during run");
      tick(CC);
      chk(busy, 1'b0, "R5 run ended");
      chk(fault, 1'b1, "R7 fault sticky after run");
    end
    cmd_cal("pd");
    chk(fault, 1'b0, "R7 fault clear at start");
    tick(2);
    pd = 1'b1;
    tick(1);
    chk(fault, 1'b1, "R6 power-down rise during run");
    pd = 1'b0;
    tick(CC);
    cmd_cal("req");
    chk(fault, 1'b0, "R7 fault clear at start");
    req = 1'b0;
    tick(3);
    req = 1'b1;
    tick(2);
    chk(fault, 1'b0, "R6 request rise not yet synchronized");
    tick(1);
    chk(fault, 1'b1, "R6 request rise during run");
    tick(CC);
  endtask

  initial begin
    t_auto(1'b0);
    t_auto(1'b1);
    t_suppress();
    t_glitch();
    t_guard();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule